// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block chooses which of the message mailboxes a CAN controller hands to its protocol engine next. Every mailbox has an enable bit, a direction bit (0 means transmit), a pending transmit request and a 6-bit software priority. Among the mailboxes that are enabled, set to transmit and holding a request, the one with the largest priority value wins. When two priorities are equal, the higher mailbox number wins. The winner is recomputed combinationally every cycle. It is frozen when the engine accepts it with a start-of-frame strobe, and it stays frozen until the engine reports success or lost arbitration.

Software raises requests by writing a mask in which each 1 sets a request. It cancels requests with a second mask. A pending mailbox that is not being sent is cancelled at once. A mailbox already handed to the engine is cancelled only if its frame loses arbitration. Successful sends and completed cancellations set sticky acknowledge flags, which are cleared by writing 1s. Either event raises a mailbox interrupt flag when that mailbox's interrupt-enable bit is set, and reports the mailbox number.

Top module: `can_tx_mbox_arb`

## Requirements
- R1: After reset, no request, acknowledge, abort-acknowledge or interrupt flag is set, `busy_o` and `sel_valid_o` are 0 and `irq_mbox_o` is 0.
- R2: A mailbox is a candidate only when its enable bit is 1, its direction bit is 0 and its request bit is 1. With no candidate and no frame in flight, `sel_valid_o` is 0 and a start strobe is ignored.
- R3: With no frame in flight, `sel_idx_o` shows in the same cycle the candidate with the largest priority value, where mailbox i's priority is bits [6*i+5:6*i] of `mbox_prio_i`. On equal priority the higher mailbox number is chosen.
- R4: A request-set write sets the request bits at the 1 positions of its mask one cycle later. Bits at the 0 positions keep their value.
- R5: A start strobe while `sel_valid_o` is 1 and no frame is in flight latches the shown index. While `busy_o` is 1, `sel_valid_o` stays 1 and `sel_idx_o` holds, whatever the requests, priorities or further strobes do.
- R6: A done report while busy clears that mailbox's request, sets its bit in `tx_ack_o` and drops `busy_o` one cycle later.
- R7: A lost-arbitration report while busy, with done low, drops `busy_o` and leaves the request pending, so the mailbox competes again.
- R8: A cancel mask clears a pending request of a mailbox that is not in flight and sets its bit in `abort_ack_o` one cycle later. A cancel bit where no request is pending has no effect.
- R9: A cancel of the in-flight mailbox is deferred. A later done report clears the request and sets `tx_ack_o` only. A later lost report clears the request and sets `abort_ack_o`.
- R10: Writing 1s to the acknowledge-clear or abort-acknowledge-clear mask clears those flag bits. A flag being set in the same cycle stays set.
- R11: When any acknowledge or abort-acknowledge bit becomes set for a mailbox whose bit in `mbox_irq_en_i` is 1, `irq_o` becomes 1 and `irq_mbox_o` takes the highest such mailbox number. Unmasked mailboxes never raise it. `irq_clr_i` clears `irq_o` unless a new event arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbox_en_i | input | NUM_MBOX | Per-mailbox enable |
| mbox_dir_i | input | NUM_MBOX | Per-mailbox direction, 0 = transmit |
| mbox_prio_i | input | NUM_MBOX*PRIO_W | Packed per-mailbox transmit priority |
| mbox_irq_en_i | input | NUM_MBOX | Per-mailbox interrupt enable |
| req_set_wr_i | input | 1 | Request-set write strobe |
| req_set_mask_i | input | NUM_MBOX | Request bits to set |
| req_abort_wr_i | input | 1 | Cancel write strobe |
| req_abort_mask_i | input | NUM_MBOX | Requests to cancel |
| ack_clr_wr_i | input | 1 | Acknowledge-clear write strobe |
| ack_clr_mask_i | input | NUM_MBOX | Acknowledge bits to clear |
| aack_clr_wr_i | input | 1 | Abort-acknowledge-clear write strobe |
| aack_clr_mask_i | input | NUM_MBOX | Abort-acknowledge bits to clear |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| eng_sof_i | input | 1 | Engine takes the shown mailbox |
| eng_done_i | input | 1 | Engine reports successful transmission |
| eng_lost_i | input | 1 | Engine reports lost arbitration |
| sel_valid_o | output | 1 | A mailbox is shown or in flight |
| sel_idx_o | output | $clog2(NUM_MBOX) | Shown or in-flight mailbox |
| busy_o | output | 1 | A frame is in flight |
| tx_req_o | output | NUM_MBOX | Pending transmit requests |
| tx_ack_o | output | NUM_MBOX | Transmit acknowledge flags |
| abort_ack_o | output | NUM_MBOX | Abort acknowledge flags |
| irq_o | output | 1 | Mailbox interrupt flag |
| irq_mbox_o | output | $clog2(NUM_MBOX) | Mailbox that raised the flag |

## Verification
The hardest case to reach is a cancel aimed at the mailbox that is already on the wire. Its outcome depends on which report the engine gives afterwards, so it cannot be seen from a pending-only mailbox. The bench first latches a chosen mailbox with a start strobe and then issues the cancel while it is busy. It checks that the request and both flags are untouched, and only then returns done in one run and lost in another. A swept set of enable, direction and priority patterns, with deliberately repeated priority values, drives the tie rule toward the higher index.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;
    localparam int unsigned MBOX_N = 32;
    localparam int unsigned PRIO_BITS = 6;

    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_DONE = 2'd1,
        OUT_LOST = 2'd2
    } eng_out_e;
endpackage

// File: rtl/can_txarb_pick.sv
module can_txarb_pick #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 6
) (
    input  logic [N-1:0]         elig_i,
    input  logic [N*PW-1:0]      prio_i,
    output logic                 hit_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned LV = IW;
    localparam int unsigned P  = 1 << LV;

    logic          nv [LV+1][P];
    logic [PW-1:0] np [LV+1][P];
    logic [IW-1:0] ni [LV+1][P];

    // balanced tree: upper child holds the larger indices, so it wins ties
    always_comb begin
        for (int l = 0; l <= int'(LV); l++) begin
            for (int k = 0; k < int'(P); k++) begin
                nv[l][k] = 1'b0;
                np[l][k] = '0;
                ni[l][k] = '0;
            end
        end
        for (int k = 0; k < int'(N); k++) begin
            nv[0][k] = elig_i[k];
            np[0][k] = prio_i[k*PW +: PW];
            ni[0][k] = IW'(k);
        end
        for (int l = 0; l < int'(LV); l++) begin
            for (int k = 0; k < int'(P >> (l + 1)); k++) begin
                if (nv[l][2*k+1] && (!nv[l][2*k] || (np[l][2*k+1] >= np[l][2*k]))) begin
                    nv[l+1][k] = 1'b1;
                    np[l+1][k] = np[l][2*k+1];
                    ni[l+1][k] = ni[l][2*k+1];
                end else begin
                    nv[l+1][k] = nv[l][2*k];
                    np[l+1][k] = np[l][2*k];
                    ni[l+1][k] = ni[l][2*k];
                end
            end
        end
        hit_o = nv[LV][0];
        idx_o = ni[LV][0];
    end
endmodule

// File: rtl/can_txarb_flags.sv
module can_txarb_flags #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr_i) begin
            st_d.bits = st_d.bits & ~clr_mask_i;
        end
        st_d.bits = st_d.bits | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.bits;
endmodule

// File: rtl/can_txarb_req.sv
module can_txarb_req
    import can_txarb_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         en_i,
    input  logic [N-1:0]         dir_i,
    input  logic                 set_wr_i,
    input  logic [N-1:0]         set_mask_i,
    input  logic                 abort_wr_i,
    input  logic [N-1:0]         abort_mask_i,
    input  logic                 sof_i,
    input  eng_out_e             outcome_i,
    input  logic                 pick_hit_i,
    input  logic [$clog2(N)-1:0] pick_idx_i,
    output logic [N-1:0]         req_o,
    output logic [N-1:0]         elig_o,
    output logic                 busy_o,
    output logic [$clog2(N)-1:0] cur_idx_o,
    output logic [N-1:0]         ack_set_o,
    output logic [N-1:0]         abt_set_o
);
    localparam int unsigned IW = $clog2(N);

    typedef struct packed {
        logic [N-1:0]  req;
        logic          busy;
        logic          abt_pend;
        logic [IW-1:0] idx;
    } req_st_t;

    req_st_t      st_d, st_q;
    logic [N-1:0] set_vec, abort_vec, fly, abt_now, ack_set, abt_late;
    logic         grant;

    always_comb begin
        st_d     = st_q;
        ack_set  = '0;
        abt_late = '0;
        set_vec   = set_wr_i ? set_mask_i : '0;
        abort_vec = abort_wr_i ? abort_mask_i : '0;
        grant = !st_q.busy && sof_i && pick_hit_i;

        fly = '0;
        if (st_q.busy) begin
            fly[st_q.idx] = 1'b1;
        end else if (grant) begin
            fly[pick_idx_i] = 1'b1;
        end

        // cancels of mailboxes not on the wire act at once
        abt_now = abort_vec & (st_q.req | set_vec) & ~fly;

        if (grant) begin
            st_d.busy     = 1'b1;
            st_d.idx      = pick_idx_i;
            st_d.abt_pend = abort_vec[pick_idx_i];
        end else if (st_q.busy) begin
            unique case (outcome_i)
                OUT_DONE: begin
                    ack_set[st_q.idx] = 1'b1;
                    st_d.busy     = 1'b0;
                    st_d.abt_pend = 1'b0;
                end
                OUT_LOST: begin
                    if (st_q.abt_pend || abort_vec[st_q.idx]) begin
                        abt_late[st_q.idx] = 1'b1;
                    end
                    st_d.busy     = 1'b0;
                    st_d.abt_pend = 1'b0;
                end
                default: begin
                    if (abort_vec[st_q.idx]) begin
                        st_d.abt_pend = 1'b1;
                    end
                end
            endcase
        end

        st_d.req = ((st_q.req & ~ack_set & ~abt_late) | set_vec) & ~abt_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o     = st_q.req;
    assign elig_o    = en_i & ~dir_i & st_q.req;
    assign busy_o    = st_q.busy;
    assign cur_idx_o = st_q.idx;
    assign ack_set_o = ack_set;
    assign abt_set_o = abt_now | abt_late;
endmodule

// File: rtl/can_tx_mbox_arb.sv
module can_tx_mbox_arb
    import can_txarb_pkg::*;
#(
    parameter int unsigned NUM_MBOX = MBOX_N,
    parameter int unsigned PRIO_W   = PRIO_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_MBOX-1:0]         mbox_en_i,
    input  logic [NUM_MBOX-1:0]         mbox_dir_i,
    input  logic [NUM_MBOX*PRIO_W-1:0]  mbox_prio_i,
    input  logic [NUM_MBOX-1:0]         mbox_irq_en_i,
    input  logic                        req_set_wr_i,
    input  logic [NUM_MBOX-1:0]         req_set_mask_i,
    input  logic                        req_abort_wr_i,
    input  logic [NUM_MBOX-1:0]         req_abort_mask_i,
    input  logic                        ack_clr_wr_i,
    input  logic [NUM_MBOX-1:0]         ack_clr_mask_i,
    input  logic                        aack_clr_wr_i,
    input  logic [NUM_MBOX-1:0]         aack_clr_mask_i,
    input  logic                        irq_clr_i,
    input  logic                        eng_sof_i,
    input  logic                        eng_done_i,
    input  logic                        eng_lost_i,
    output logic                        sel_valid_o,
    output logic [$clog2(NUM_MBOX)-1:0] sel_idx_o,
    output logic                        busy_o,
    output logic [NUM_MBOX-1:0]         tx_req_o,
    output logic [NUM_MBOX-1:0]         tx_ack_o,
    output logic [NUM_MBOX-1:0]         abort_ack_o,
    output logic                        irq_o,
    output logic [$clog2(NUM_MBOX)-1:0] irq_mbox_o
);
    localparam int unsigned IW = $clog2(NUM_MBOX);

    typedef struct packed {
        logic          flag;
        logic [IW-1:0] mbox;
    } irq_st_t;

    eng_out_e            outcome;
    logic [NUM_MBOX-1:0] elig, ack_set, abt_set, ev;
    logic                pick_hit, busy;
    logic [IW-1:0]       pick_idx, cur_idx, ev_hi;
    irq_st_t             irq_d, irq_q;

    always_comb begin
        if (eng_done_i) begin
            outcome = OUT_DONE;
        end else if (eng_lost_i) begin
            outcome = OUT_LOST;
        end else begin
            outcome = OUT_NONE;
        end
    end

    can_txarb_pick #(.N(NUM_MBOX), .PW(PRIO_W)) u_pick (
        .elig_i (elig),
        .prio_i (mbox_prio_i),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx)
    );

    can_txarb_req #(.N(NUM_MBOX)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (mbox_en_i),
        .dir_i        (mbox_dir_i),
        .set_wr_i     (req_set_wr_i),
        .set_mask_i   (req_set_mask_i),
        .abort_wr_i   (req_abort_wr_i),
        .abort_mask_i (req_abort_mask_i),
        .sof_i        (eng_sof_i),
        .outcome_i    (outcome),
        .pick_hit_i   (pick_hit),
        .pick_idx_i   (pick_idx),
        .req_o        (tx_req_o),
        .elig_o       (elig),
        .busy_o       (busy),
        .cur_idx_o    (cur_idx),
        .ack_set_o    (ack_set),
        .abt_set_o    (abt_set)
    );

    can_txarb_flags #(.N(NUM_MBOX)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ack_set),
        .clr_wr_i   (ack_clr_wr_i),
        .clr_mask_i (ack_clr_mask_i),
        .flags_o    (tx_ack_o)
    );

    can_txarb_flags #(.N(NUM_MBOX)) u_aack (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (abt_set),
        .clr_wr_i   (aack_clr_wr_i),
        .clr_mask_i (aack_clr_mask_i),
        .flags_o    (abort_ack_o)
    );

    always_comb begin
        ev    = (ack_set | abt_set) & mbox_irq_en_i;
        ev_hi = '0;
        for (int i = 0; i < int'(NUM_MBOX); i++) begin
            if (ev[i]) begin
                ev_hi = IW'(i);
            end
        end
        irq_d = irq_q;
        if (irq_clr_i) begin
            irq_d.flag = 1'b0;
        end
        if (|ev) begin
            irq_d.flag = 1'b1;
            irq_d.mbox = ev_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign busy_o      = busy;
    assign sel_valid_o = busy | pick_hit;
    assign sel_idx_o   = busy ? cur_idx : pick_idx;
    assign irq_o       = irq_q.flag;
    assign irq_mbox_o  = irq_q.mbox;
endmodule

// File: rtl/can_txarb_chk.sv
module can_txarb_chk #(
    parameter int unsigned N = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         mbox_en_i,
    input logic [N-1:0]         mbox_dir_i,
    input logic                 req_set_wr_i,
    input logic [N-1:0]         req_set_mask_i,
    input logic                 eng_done_i,
    input logic                 eng_lost_i,
    input logic                 sel_valid_o,
    input logic [$clog2(N)-1:0] sel_idx_o,
    input logic                 busy_o,
    input logic [N-1:0]         tx_req_o,
    input logic [N-1:0]         tx_ack_o,
    input logic [N-1:0]         abort_ack_o,
    input logic                 irq_o,
    input logic [$clog2(N)-1:0] irq_mbox_o
);
    // R5
    hold_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !eng_done_i && !eng_lost_i |=> busy_o && $stable(sel_idx_o));

    // R2
    candidate_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o && !busy_o |-> mbox_en_i[sel_idx_o] && !mbox_dir_i[sel_idx_o] && tx_req_o[sel_idx_o]);

    // R6
    done_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && eng_done_i && !(req_set_wr_i && req_set_mask_i[sel_idx_o])
        |=> !busy_o && tx_ack_o[$past(sel_idx_o)] && !tx_req_o[$past(sel_idx_o)]);

    // R7
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && eng_lost_i && !eng_done_i |=> !busy_o);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !$past(irq_o) |-> (tx_ack_o[irq_mbox_o] || abort_ack_o[irq_mbox_o]));
endmodule

bind can_tx_mbox_arb can_txarb_chk #(.N(NUM_MBOX)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mbox_en_i      (mbox_en_i),
    .mbox_dir_i     (mbox_dir_i),
    .req_set_wr_i   (req_set_wr_i),
    .req_set_mask_i (req_set_mask_i),
    .eng_done_i     (eng_done_i),
    .eng_lost_i     (eng_lost_i),
    .sel_valid_o    (sel_valid_o),
    .sel_idx_o      (sel_idx_o),
    .busy_o         (busy_o),
    .tx_req_o       (tx_req_o),
    .tx_ack_o       (tx_ack_o),
    .abort_ack_o    (abort_ack_o),
    .irq_o          (irq_o),
    .irq_mbox_o     (irq_mbox_o)
);

// File: tb/can_tx_mbox_arb_test.sv
`timescale 1ns/1ps
module can_tx_mbox_arb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] en = '0, dir = '0, irq_en = '0;
    logic [5:0]  pr [32];
    logic [191:0] prio_flat;
    logic        set_wr = 0, abt_wr = 0, ack_wr = 0, aack_wr = 0, irq_clr = 0;
    logic [31:0] set_m = '0, abt_m = '0, ack_m = '0, aack_m = '0;
    logic        sof = 0, done = 0, lost = 0;
    logic        sel_valid, busy, irq;
    logic [4:0]  sel_idx, irq_mbox;
    logic [31:0] tx_req, tx_ack, abort_ack;
    int          n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 32; i++) prio_flat[i*6 +: 6] = pr[i];
    end

    can_tx_mbox_arb uut (
        .clk(clk), .rst_n(rst_n), .mbox_en_i(en), .mbox_dir_i(dir),
        .mbox_prio_i(prio_flat), .mbox_irq_en_i(irq_en),
        .req_set_wr_i(set_wr), .req_set_mask_i(set_m),
        .req_abort_wr_i(abt_wr), .req_abort_mask_i(abt_m),
        .ack_clr_wr_i(ack_wr), .ack_clr_mask_i(ack_m),
        .aack_clr_wr_i(aack_wr), .aack_clr_mask_i(aack_m),
        .irq_clr_i(irq_clr), .eng_sof_i(sof), .eng_done_i(done), .eng_lost_i(lost),
        .sel_valid_o(sel_valid), .sel_idx_o(sel_idx), .busy_o(busy),
        .tx_req_o(tx_req), .tx_ack_o(tx_ack), .abort_ack_o(abort_ack),
        .irq_o(irq), .irq_mbox_o(irq_mbox)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_set(input logic [31:0] m);
        set_wr = 1; set_m = m; cyc(); set_wr = 0; set_m = '0;
    endtask

    task automatic wr_abort(input logic [31:0] m);
        abt_wr = 1; abt_m = m; cyc(); abt_wr = 0; abt_m = '0;
    endtask

    task automatic eng(input logic s, input logic d, input logic l);
        sof = s; done = d; lost = l; cyc(); sof = 0; done = 0; lost = 0;
    endtask

    task automatic clr_all();
        ack_wr = 1; ack_m = '1; aack_wr = 1; aack_m = '1; irq_clr = 1;
        cyc();
        ack_wr = 0; ack_m = '0; aack_wr = 0; aack_m = '0; irq_clr = 0;
    endtask

    // bench model of the choice, from R2 and R3
    function automatic logic [5:0] model_pick(input logic [31:0] req);
        logic       found = 0;
        logic [5:0] best = 0;
        logic [4:0] idx = 0;
        for (int i = 0; i < 32; i++) begin
            if (en[i] && !dir[i] && req[i] && (!found || pr[i] >= best)) begin
                found = 1; best = pr[i]; idx = 5'(i);
            end
        end
        return {found, idx};
    endfunction

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog expired R1 act=%0d exp=0", 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] e;
        for (int i = 0; i < 32; i++) pr[i] = '0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 req", tx_req, 0);
        chk("R1 ack", tx_ack, 0);
        chk("R1 aack", abort_ack, 0);
        chk("R1 valid", {31'b0, sel_valid}, 0);
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 irqmbox", {27'b0, irq_mbox}, 0);

        // R4 set mask semantics
        wr_set(32'h0000_00F0);
        chk("R4 first", tx_req, 32'h0000_00F0);
        wr_set(32'h0000_0003);
        chk("R4 zeros keep", tx_req, 32'h0000_00F3);
        wr_set(32'hFFFF_FFFF);
        chk("R4 all", tx_req, 32'hFFFF_FFFF);

        // R3 R2 sweep over enables, directions and priorities
        for (int k = 0; k < 300; k++) begin
            en  = (k % 17 == 5) ? 32'h0 : (32'(k) * 32'h9E37_79B9) ^ (32'(k) << 7);
            dir = (32'(k) * 32'h85EB_CA6B) >> 3;
            for (int i = 0; i < 32; i++)
                pr[i] = 6'(((i * 5 + k * 11) ^ (k >> 2)) % ((k % 3 == 0) ? 4 : 64));
            #1;
            e = model_pick(tx_req);
            chk($sformatf("R2 valid k=%0d", k), {31'b0, sel_valid}, {31'b0, e[5]});
            if (e[5]) chk($sformatf("R3 idx k=%0d", k), {27'b0, sel_idx}, {27'b0, e[4:0]});
            cyc();
        end
        // R3 all equal: highest number wins
        en = '1; dir = '0;
        for (int i = 0; i < 32; i++) pr[i] = 6'h3F;
        #1 chk("R3 tie top", {27'b0, sel_idx}, 31);
        pr[0] = 6'h3F; for (int i = 1; i < 32; i++) pr[i] = 6'h3E;
        #1 chk("R3 unique low", {27'b0, sel_idx}, 0);
        cyc();

        // R8 cancel all idle requests, unmasked -> no irq (R11)
        wr_abort('1);
        chk("R8 req cleared", tx_req, 0);
        chk("R8 aack set", abort_ack, 32'hFFFF_FFFF);
        chk("R11 masked off", {31'b0, irq}, 0);
        aack_wr = 1; aack_m = 32'h0000_FFFF; cyc(); aack_wr = 0; aack_m = '0;
        chk("R10 partial clr", abort_ack, 32'hFFFF_0000);
        clr_all();
        chk("R10 aack clr", abort_ack, 0);

        // R8 cancel with nothing pending
        irq_en = '1;
        for (int i = 0; i < 32; i++) pr[i] = 0;
        wr_abort(32'h0000_0008);
        chk("R8 no effect aack", abort_ack, 0);
        chk("R8 no effect irq", {31'b0, irq}, 0);

        // R5 R6 latch and succeed
        pr[5] = 10; pr[9] = 4;
        wr_set((32'h1 << 5) | (32'h1 << 9));
        #1 chk("R3 pick5", {27'b0, sel_idx}, 5);
        cyc();
        eng(1, 0, 0);
        chk("R5 busy", {31'b0, busy}, 1);
        chk("R5 idx", {27'b0, sel_idx}, 5);
        pr[9] = 20; pr[12] = 63;
        wr_set(32'h1 << 12);
        eng(1, 0, 0);
        chk("R5 frozen idx", {27'b0, sel_idx}, 5);
        chk("R5 frozen valid", {31'b0, sel_valid}, 1);
        eng(0, 1, 0);
        chk("R6 not busy", {31'b0, busy}, 0);
        chk("R6 ack", tx_ack, 32'h1 << 5);
        chk("R6 req", tx_req, (32'h1 << 9) | (32'h1 << 12));
        chk("R11 irq", {31'b0, irq}, 1);
        chk("R11 mbox", {27'b0, irq_mbox}, 5);
        #1 chk("R3 next pick", {27'b0, sel_idx}, 12);
        clr_all();
        chk("R10 ack clr", tx_ack, 0);
        chk("R11 irq clr", {31'b0, irq}, 0);

        // R7 lost arbitration keeps request
        eng(1, 0, 0);
        chk("R7 latched", {27'b0, sel_idx}, 12);
        eng(0, 0, 1);
        chk("R7 idle", {31'b0, busy}, 0);
        chk("R7 req kept", tx_req, (32'h1 << 9) | (32'h1 << 12));
        chk("R7 no ack", tx_ack, 0);
        chk("R7 no irq", {31'b0, irq}, 0);
        #1 chk("R7 again", {27'b0, sel_idx}, 12);
        cyc();

        // R9 deferred cancel then success
        eng(1, 0, 0);
        wr_abort(32'h1 << 12);
        chk("R9 deferred req", tx_req, (32'h1 << 9) | (32'h1 << 12));
        chk("R9 deferred aack", abort_ack, 0);
        chk("R9 still busy", {31'b0, busy}, 1);
        eng(0, 1, 0);
        chk("R9 done ack", tx_ack, 32'h1 << 12);
        chk("R9 done no aack", abort_ack, 0);
        chk("R9 done req", tx_req, 32'h1 << 9);
        clr_all();

        // R9 deferred cancel then lost
        eng(1, 0, 0);
        chk("R9 latched9", {27'b0, sel_idx}, 9);
        wr_abort(32'h1 << 9);
        eng(0, 0, 1);
        chk("R9 lost req", tx_req, 0);
        chk("R9 lost aack", abort_ack, 32'h1 << 9);
        chk("R9 lost ack", tx_ack, 0);
        chk("R11 abort irq", {27'b0, irq_mbox}, 9);
        clr_all();

        // R11 highest masked mailbox is reported
        irq_en = (32'h1 << 2) | (32'h1 << 7);
        wr_set((32'h1 << 2) | (32'h1 << 7) | (32'h1 << 20));
        wr_abort((32'h1 << 2) | (32'h1 << 7) | (32'h1 << 20));
        chk("R8 multi aack", abort_ack, (32'h1 << 2) | (32'h1 << 7) | (32'h1 << 20));
        chk("R11 multi irq", {31'b0, irq}, 1);
        chk("R11 multi mbox", {27'b0, irq_mbox}, 7);
        clr_all();

        // R10 set wins over clear, R11 new event beats clear
        irq_en = '1;
        wr_set(32'h1 << 4);
        eng(1, 0, 0);
        chk("R5 latch4", {27'b0, sel_idx}, 4);
        irq_clr = 1; ack_wr = 1; ack_m = 32'h1 << 4;
        eng(0, 1, 0);
        irq_clr = 0; ack_wr = 0; ack_m = '0;
        chk("R10 set wins", tx_ack, 32'h1 << 4);
        chk("R11 event beats clr", {31'b0, irq}, 1);
        chk("R11 mbox4", {27'b0, irq_mbox}, 4);
        clr_all();

        // R2 direction and enable gate candidacy
        pr[30] = 63; pr[1] = 0;
        dir = 32'h1 << 30;
        wr_set((32'h1 << 30) | (32'h1 << 1));
        #1 chk("R2 dir blocks", {27'b0, sel_idx}, 1);
        en = ~(32'h1 << 1);
        #1 chk("R2 none valid", {31'b0, sel_valid}, 0);
        cyc();
        eng(1, 0, 0);
        chk("R2 sof ignored", {31'b0, busy}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule